// File: doc/BRIEF.md
# Free-Running Compare Timer with Interrupt Vector

This block is a free-running up-counter shared by several compare channels. Each channel holds a compare value and raises a flag when the counter is exactly equal to it. In toggle mode the channel also inverts its output pin on that clock. Software produces a periodic square wave with no added jitter by adding a fixed interval to the compare value after every match. Because the counter is never cleared, channels with unrelated intervals can share it. A wrap of the counter from all-ones to zero sets an overflow flag.

Channel 0 drives its own interrupt line, and its flag is cleared by an acknowledge pulse. The remaining channels and the overflow share a second line. That line is served by a vector register that returns an even code for the most urgent enabled source and clears only that source's flag as it is read. Channel slots up to 4 are reserved in the address map and in the code space. Slots beyond `NUM_CH` read as zero. Registers are reached over a simple single-cycle bus, and read data is registered.

Address map (5-bit word address): 0 = control (bit0 overflow enable, bit1 overflow flag); 1 = counter (read only); 2 = vector (read only); 8+k = channel k control (bit0 enable, bit1 flag, bit2 mode with 1 = toggle and 0 = plain output, bit3 output level); 16+k = channel k compare; 24+k = a write adds the data to channel k compare, and a read returns the compare value.

Top module: `tmr_top`

## Requirements
- R1: The counter resets to 0, adds 1 on every clock, wraps from 2^CNT_W-1 to 0, and reads at address 1 with the value it held on the clock of the read.
- R2: The clock on which the counter wraps sets the overflow flag (control bit1). Control bit0 enables the overflow as a shared-interrupt source.
- R3: In toggle mode (control bit2 = 1) a channel's output inverts on each clock where the counter equals its compare value. The match is on equality only, so a compare value already passed by the counter causes no inversion.
- R4: A compare write (address 16+k) or add (address 24+k, sum modulo 2^CNT_W) is used from the next clock. An add of N after each match makes the output invert every N clocks.
- R5: In plain mode (bit2 = 0) the output pin equals the written level bit3, and matches do not change it.
- R6: A match sets the channel flag (bit1) in every mode. A match while the flag is already set leaves it set and queues nothing extra. A match wins over a clear in the same clock.
- R7: irq_ch0 is high while the channel 0 flag and enable are both set. A one-clock ch0_ack pulse clears the channel 0 flag.
- R8: irq_shared is high exactly when some enabled source among channels 1 and up or the overflow has its flag set. Channel 0 never drives it.
- R9: The vector register (address 2) reads 0 for none, 2·k for channel k (k = 1..4) and 10 for overflow. It reports the lowest-numbered enabled channel first and the overflow last, and it ignores flags whose enable bit is 0.
- R10: Reading the vector register clears only the flag it reported. Other pending flags stay set and keep irq_shared high.
- R11: Channel slots at or above NUM_CH read 0 at their addresses even after writes, and their codes (6 and 8 when NUM_CH = 3) are never returned.
- R12: During reset all outputs, bus_rdata and the channel pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register word address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, data valid on the following clock |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ch0_ack | input | 1 | Acknowledge of the channel 0 interrupt |
| ch_out | output | NUM_CH | Channel output pins |
| irq_ch0 | output | 1 | Dedicated interrupt of channel 0 |
| irq_shared | output | 1 | Shared interrupt of channels 1 and up and the overflow |

## Verification
The bench builds the block with CNT_W = 8 and NUM_CH = 3. The 8-bit counter wraps every 256 clocks, so the overflow flag, counter wrap-around and compare arithmetic modulo the counter width all occur within a short directed run. With three channels, slots 3 and 4 are empty, which lets the bench confirm that reserved addresses read zero and that codes 6 and 8 never appear from the vector register.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int MAX_CH = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 5'd1;
  localparam logic [ADDR_W-1:0] A_VEC   = 5'd2;
  localparam int A_CCTL_BASE = 8;
  localparam int A_CMP_BASE  = 16;
  localparam int A_ADD_BASE  = 24;

  // channel control bit positions
  localparam int B_IE   = 0;
  localparam int B_FLAG = 1;
  localparam int B_MODE = 2;
  localparam int B_OUT  = 3;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'd0;
  localparam logic [CODE_W-1:0] CODE_OVF  = 4'd10;

  function automatic logic [ADDR_W-1:0] ch_addr(input int base, input int k);
    return ADDR_W'(base + k);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // high on the clock whose edge takes the counter back to zero
  assign wrap = &cnt;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctl_wr,
  input  logic             cmp_wr,
  input  logic             cmp_add,
  input  logic [DATA_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag_q,
  output logic             ie_q,
  output logic             mode_q,
  output logic             out_q
);
  logic match;
  assign match = (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (cmp_wr)       cmp_q <= wdata[CNT_W-1:0];
      else if (cmp_add) cmp_q <= cmp_q + wdata[CNT_W-1:0];

      if (ctl_wr) begin
        ie_q   <= wdata[B_IE];
        mode_q <= wdata[B_MODE];
      end

      // a match always wins so no event is lost
      if (match)         flag_q <= 1'b1;
      else if (ctl_wr)   flag_q <= wdata[B_FLAG];
      else if (flag_clr) flag_q <= 1'b0;

      if (mode_q && match) out_q <= ~out_q;
      else if (ctl_wr)     out_q <= wdata[B_OUT];
    end
  end
endmodule

// File: rtl/tmr_vector.sv
`timescale 1ns/1ps
module tmr_vector
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] pend_ch,
  input  logic              pend_ovf,
  output logic [CODE_W-1:0] code,
  output logic [NUM_CH-1:0] sel_ch,
  output logic              sel_ovf
);
  // overflow is weakest; walk channels downward so the lowest wins
  always_comb begin
    code    = CODE_NONE;
    sel_ch  = '0;
    sel_ovf = 1'b0;
    if (pend_ovf) begin
      code    = CODE_OVF;
      sel_ovf = 1'b1;
    end
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (pend_ch[k] && k != 0) begin
        code      = CODE_W'(2 * k);
        sel_ch    = '0;
        sel_ch[k] = 1'b1;
        sel_ovf   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
`timescale 1ns/1ps
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ch0_ack,
  output logic [NUM_CH-1:0] ch_out,
  output logic              irq_ch0,
  output logic              irq_shared
);
  localparam logic [NUM_CH-1:0] SH_MASK = ~NUM_CH'(1);

  logic [CNT_W-1:0]             cnt;
  logic                         wrap;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CH-1:0]            flag_q, ie_q, mode_q;
  logic [NUM_CH-1:0]            ctl_wr, cmp_wr, cmp_add, flag_clr;
  logic [NUM_CH-1:0]            pend_ch, sel_ch;
  logic                         ovf_ie, ovf_flag, pend_ovf, sel_ovf;
  logic [CODE_W-1:0]            vec_code;
  logic                         vec_rd, ctrl_wr;
  logic [DATA_W-1:0]            rd_mux;

  assign vec_rd  = bus_rd && (bus_addr == A_VEC);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .wrap (wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ctl_wr[k]   = bus_wr && (bus_addr == ch_addr(A_CCTL_BASE, k));
    assign cmp_wr[k]   = bus_wr && (bus_addr == ch_addr(A_CMP_BASE, k));
    assign cmp_add[k]  = bus_wr && (bus_addr == ch_addr(A_ADD_BASE, k));
    assign flag_clr[k] = (k == 0) ? ch0_ack : (vec_rd && sel_ch[k]);
    assign pend_ch[k]  = flag_q[k] && ie_q[k];

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .ctl_wr   (ctl_wr[k]),
      .cmp_wr   (cmp_wr[k]),
      .cmp_add  (cmp_add[k]),
      .wdata    (bus_wdata),
      .flag_clr (flag_clr[k]),
      .cmp_q    (cmp_q[k]),
      .flag_q   (flag_q[k]),
      .ie_q     (ie_q[k]),
      .mode_q   (mode_q[k]),
      .out_q    (ch_out[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_ie   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_wr) ovf_ie <= bus_wdata[0];
      if (wrap)                    ovf_flag <= 1'b1;
      else if (ctrl_wr)            ovf_flag <= bus_wdata[1];
      else if (vec_rd && sel_ovf)  ovf_flag <= 1'b0;
    end
  end

  assign pend_ovf = ovf_flag && ovf_ie;

  tmr_vector #(.NUM_CH(NUM_CH)) u_vec (
    .pend_ch  (pend_ch),
    .pend_ovf (pend_ovf),
    .code     (vec_code),
    .sel_ch   (sel_ch),
    .sel_ovf  (sel_ovf)
  );

  assign irq_ch0    = pend_ch[0];
  assign irq_shared = pend_ovf || (|(pend_ch & SH_MASK));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL)  rd_mux = DATA_W'({ovf_flag, ovf_ie});
    if (bus_addr == A_COUNT) rd_mux = DATA_W'(cnt);
    if (bus_addr == A_VEC)   rd_mux = DATA_W'(vec_code);
    for (int k = 0; k < NUM_CH; k++) begin
      if (bus_addr == ch_addr(A_CCTL_BASE, k))
        rd_mux = DATA_W'({ch_out[k], mode_q[k], flag_q[k], ie_q[k]});
      if (bus_addr == ch_addr(A_CMP_BASE, k) || bus_addr == ch_addr(A_ADD_BASE, k))
        rd_mux = DATA_W'(cmp_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_top_chk.sv
`timescale 1ns/1ps
module tmr_top_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_wr,
  input logic                         ch0_ack,
  input logic [CNT_W-1:0]             cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_q,
  input logic [NUM_CH-1:0]            mode_q,
  input logic [NUM_CH-1:0]            flag_q,
  input logic [NUM_CH-1:0]            ch_out,
  input logic                         ovf_flag,
  input logic [CODE_W-1:0]            vec_code,
  input logic                         irq_ch0,
  input logic                         irq_shared
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> ovf_flag);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
      (mode_q[k] && cnt == cmp_q[k]) |=> ch_out[k] != $past(ch_out[k]));
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (mode_q[k] && cnt != cmp_q[k] && !bus_wr) |=> $stable(ch_out[k]));
    assert_plain_R5: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[k] && !bus_wr) |=> $stable(ch_out[k]));
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt == cmp_q[k]) |=> flag_q[k]);
  end

  assert_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (ch0_ack && cnt != cmp_q[0] && !bus_wr) |=> !irq_ch0);

  assert_shared_R8: assert property (@(posedge clk) disable iff (rst)
    irq_shared == (vec_code != CODE_NONE));

  assert_code_R9: assert property (@(posedge clk) disable iff (rst)
    !vec_code[0] && vec_code <= CODE_OVF);

  if (NUM_CH < 4) begin : g_no3
    assert_absent3_R11: assert property (@(posedge clk) disable iff (rst)
      vec_code != 4'd6);
  end
  if (NUM_CH < 5) begin : g_no4
    assert_absent4_R11: assert property (@(posedge clk) disable iff (rst)
      vec_code != 4'd8);
  end
endmodule

bind tmr_top tmr_top_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .ch0_ack    (ch0_ack),
  .cnt        (cnt),
  .cmp_q      (cmp_q),
  .mode_q     (mode_q),
  .flag_q     (flag_q),
  .ch_out     (ch_out),
  .ovf_flag   (ovf_flag),
  .vec_code   (vec_code),
  .irq_ch0    (irq_ch0),
  .irq_shared (irq_shared)
);

// File: tb/test_tmr_top.sv
`timescale 1ns/1ps
module test_tmr_top;
  localparam int CW = 8;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ch0_ack = 1'b0;
  logic [NC-1:0] ch_out;
  logic        irq_ch0, irq_shared;

  int n_cmp = 0;
  int n_err = 0;
  logic [CW-1:0] m_cnt;

  always #5 clk = ~clk;

  // counter model from R1
  always @(posedge clk) begin
    if (rst) m_cnt <= '0;
    else     m_cnt <= m_cnt + 1'b1;
  end

  tmr_top #(.CNT_W(CW), .NUM_CH(NC)) i_tmr_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch0_ack(ch0_ack),
    .ch_out(ch_out), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_cnt(input logic [CW-1:0] t);
    while (m_cnt != t) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 ch_out", int'(ch_out), 0);
    check("R12 irq_ch0", int'(irq_ch0), 0);
    check("R12 irq_shared", int'(irq_shared), 0);
    check("R12 rdata", int'(bus_rdata), 0);
  endtask

  task automatic t_counter;
    logic [15:0] d;
    logic [CW-1:0] e;
    wait_cnt(8'd37);
    e = m_cnt;
    rd(5'd1, d);
    check("R1 count read", int'(d), int'(e));
    wait_cnt(8'd255);
    rd(5'd1, d);
    check("R1 count top", int'(d), 255);
    rd(5'd1, d);
    check("R1 count wrap", int'(d), 0);
  endtask

  task automatic t_overflow;
    logic [15:0] d;
    wait_cnt(8'd100);
    wr(5'd0, 16'h0001);
    wait_cnt(8'd255);
    check("R2 no flag before wrap", int'(irq_shared), 0);
    tick(1);
    check("R2 irq after wrap", int'(irq_shared), 1);
    rd(5'd0, d);
    check("R2 control flag+enable", int'(d), 3);
    rd(5'd2, d);
    check("R9 overflow code", int'(d), 10);
    check("R10 irq cleared by read", int'(irq_shared), 0);
    wr(5'd0, 16'h0000);
  endtask

  task automatic t_toggle;
    logic [15:0] d;
    logic [CW-1:0] v;
    wait_cnt(8'd10);
    wr(5'd17, 16'd40);
    wr(5'd9, 16'h0004);
    check("R3 start level", int'(ch_out[1]), 0);
    wait_cnt(8'd40);
    check("R3 before match", int'(ch_out[1]), 0);
    tick(1);
    check("R3 toggle on match", int'(ch_out[1]), 1);
    wr(5'd25, 16'd30);
    wait_cnt(8'd70);
    check("R4 before next interval", int'(ch_out[1]), 1);
    tick(1);
    check("R4 toggle after interval", int'(ch_out[1]), 0);
    rd(5'd17, d);
    check("R4 compare after add", int'(d), 70);
    v = m_cnt;
    wr(5'd17, 16'(v + 8'd1));
    check("R4 not yet matched", int'(ch_out[1]), 0);
    tick(1);
    check("R4 new compare used next clock", int'(ch_out[1]), 1);
    v = m_cnt;
    wr(5'd17, 16'(v));
    tick(20);
    check("R3 passed value no toggle", int'(ch_out[1]), 1);
  endtask

  task automatic t_plain;
    logic [15:0] d;
    logic [CW-1:0] t;
    t = m_cnt + 8'd6;
    wr(5'd18, 16'(t));
    wr(5'd10, 16'h0008);
    check("R5 level written", int'(ch_out[2]), 1);
    wait_cnt(t);
    tick(1);
    check("R5 match no change", int'(ch_out[2]), 1);
    rd(5'd10, d);
    check("R6 flag set in plain mode", int'(d), 16'h000A);
    wr(5'd10, 16'h0000);
    check("R5 level cleared", int'(ch_out[2]), 0);
  endtask

  task automatic t_no_queue;
    logic [15:0] d;
    logic [CW-1:0] t;
    t = m_cnt + 8'd6;
    wr(5'd17, 16'(t));
    wr(5'd9, 16'h0003);
    wait_cnt(t);
    tick(2);
    rd(5'd2, d);
    check("R6 flag still set", int'(d), 2);
    rd(5'd2, d);
    check("R6 nothing queued", int'(d), 0);
    check("R8 irq low", int'(irq_shared), 0);
    wr(5'd9, 16'h0000);
  endtask

  task automatic t_vector;
    logic [15:0] d;
    wait_cnt(8'd20);
    wr(5'd17, 16'd200);
    wr(5'd18, 16'd200);
    wr(5'd9, 16'h0003);
    wr(5'd10, 16'h0003);
    wr(5'd0, 16'h0003);
    check("R8 shared irq", int'(irq_shared), 1);
    check("R8 channel 0 not shared", int'(irq_ch0), 0);
    rd(5'd2, d);
    check("R9 lowest channel first", int'(d), 2);
    check("R10 others keep irq", int'(irq_shared), 1);
    rd(5'd10, d);
    check("R10 channel 2 flag kept", int'(d), 3);
    rd(5'd2, d);
    check("R9 channel 2 code", int'(d), 4);
    rd(5'd2, d);
    check("R9 overflow last", int'(d), 10);
    rd(5'd2, d);
    check("R9 none", int'(d), 0);
    wr(5'd9, 16'h0002);
    wr(5'd0, 16'h0003);
    rd(5'd2, d);
    check("R9 disabled source skipped", int'(d), 10);
    rd(5'd9, d);
    check("R10 unreported flag kept", int'(d), 2);
    wr(5'd9, 16'h0000);
    wr(5'd10, 16'h0000);
    wr(5'd0, 16'h0000);
  endtask

  task automatic t_ch0;
    logic [CW-1:0] t;
    t = m_cnt + 8'd6;
    wr(5'd16, 16'(t));
    wr(5'd8, 16'h0001);
    wait_cnt(t);
    check("R7 before match", int'(irq_ch0), 0);
    tick(1);
    check("R7 irq on match", int'(irq_ch0), 1);
    check("R8 channel 0 not shared", int'(irq_shared), 0);
    ch0_ack = 1'b1;
    tick(1);
    ch0_ack = 1'b0;
    check("R7 ack clears", int'(irq_ch0), 0);
  endtask

  task automatic t_absent;
    logic [15:0] d;
    wr(5'd11, 16'h000F);
    rd(5'd11, d);
    check("R11 slot 3 reads zero", int'(d), 0);
    wr(5'd20, 16'h00FF);
    rd(5'd20, d);
    check("R11 slot 4 reads zero", int'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_counter();
    t_overflow();
    t_toggle();
    t_plain();
    t_no_queue();
    t_vector();
    t_ch0();
    t_absent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule